// File: doc/BRIEF.md
# Add-Compare-Select Path Metric Unit

This block updates the state metrics of a rate-1/2 convolutional decoder whose trellis has 2^M states. Each accepted trellis step brings four branch metrics, one for each possible pair of code bits. For every state, two add-compare-select operations run in the same cycle. Each one adds a branch metric to the metric of one of the two predecessors, compares the two sums and keeps the smaller. The outcome is a fresh metric vector and one decision bit per state. Branch metric generation and survivor storage sit outside the block. The decision vector can drive a traceback memory directly, because each bit is the earliest encoder bit of the winning predecessor.

The two-input compare-select cell scans its operands from the most significant bit down. It stops at the first position where they differ. The same cell is used in every ACS unit and in the tree that finds the smallest new metric. That minimum is subtracted from every metric before the metrics are stored, so the stored values never drift upward. Sums that pass the metric range are clamped at the largest value.

A small controller has two states. After reset it is in ST_IDLE and ignores valid steps that do not carry `start`. The transition ST_IDLE to ST_RUN happens on a valid step with `start`. ST_RUN stays in ST_RUN, and a later step with `start` re-seeds the metrics without leaving ST_RUN.

Top module: `acs_pmu`

## Requirements
- R1: Trellis wiring. State j (bit M-1 is the earliest encoder bit, bit 0 the newest) has predecessors p0 = j>>1 (earliest bit b=0) and p1 = (j>>1) + 2^(M-1) (b=1). The branch from the predecessor with bit b uses symbol index 2*c0 + c1, where ci is the parity of Gi AND the (M+1)-bit value {b, j}. Its metric is read from `bm_in[sym*BW +: BW]`.
- R2: The new metric of a state is the smaller of its two candidate sums. Each sum is predecessor metric plus branch metric, clamped to 2^W-1 when it overflows.
- R3: Before they are stored, all new metrics are reduced by their common minimum. On every valid output at least one metric is zero.
- R4: Decision bit j is the earliest bit b of the predecessor that won. When the two sums are equal, b=0 is chosen.
- R5: On a valid step with `start` high, the predecessor metrics are 0 for state 0 and INIT for every other state, replacing the stored ones. With INIT above the largest branch metric, decision bits 0 and 1 are then 0.
- R6: After reset the controller is in ST_IDLE. A valid step without `start` is ignored there: no `valid_out`, and the metrics stay at their reset value.
- R7: `valid_out` is high in exactly the cycle after an accepted step. An accepted step is one with `valid_in` high, taken in ST_RUN or carrying `start`. Metrics and decisions are updated in that same cycle.
- R8: When `valid_in` is low, `valid_out` is low and `pm_out` and `dec_out` keep their values.
- R9: Reset clears `valid_out`, every metric and every decision bit to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_in | input | 1 | A trellis step is offered this cycle |
| start | input | 1 | First step of a block; seeds the metrics |
| bm_in | input | 4*BW | Four branch metrics, slot = 2*c0 + c1 |
| valid_out | output | 1 | Updated metrics and decisions are present |
| pm_out | output | 2^M*W | State metrics, state j at bits j*W +: W |
| dec_out | output | 2^M | Decision bit per state |

## Verification
The stored metrics are the output registers. A wrong metric, a wrong clamp or a missed normalization therefore appears on `pm_out` in the cycle after the step that caused it. The bench compares every state against a reference model that runs on integers. A wrong tie rule or swapped predecessor wiring flips bits of `dec_out` on that same output. A controller stuck in the wrong state shows as a missing or extra `valid_out` pulse on the next edge. The hold rows catch registers that change while no step is offered.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pmu_state_e;

endpackage

// File: rtl/pmu_cs2.sv
// Two-input compare-select decision: scans from the top bit downward and
// stops at the first bit where the operands disagree.
module pmu_cs2 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         pick_b_o
);

    logic seen;

    always_comb begin
        seen     = 1'b0;
        pick_b_o = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!seen && (a_i[i] != b_i[i])) begin
                seen     = 1'b1;
                pick_b_o = a_i[i];   // a holds the 1 -> a larger -> take b
            end
        end
    end

endmodule

// File: rtl/pmu_acs.sv
module pmu_acs #(
    parameter int W  = 8,
    parameter int BW = 4
) (
    input  logic [W-1:0]  pm0_i,
    input  logic [W-1:0]  pm1_i,
    input  logic [BW-1:0] bm0_i,
    input  logic [BW-1:0] bm1_i,
    output logic [W-1:0]  pm_o,
    output logic          dec_o
);

    logic [W:0]   wide0, wide1;
    logic [W-1:0] sum0, sum1;

    assign wide0 = {1'b0, pm0_i} + (W+1)'(bm0_i);
    assign wide1 = {1'b0, pm1_i} + (W+1)'(bm1_i);
    assign sum0  = wide0[W] ? {W{1'b1}} : wide0[W-1:0];
    assign sum1  = wide1[W] ? {W{1'b1}} : wide1[W-1:0];

    pmu_cs2 #(.W(W)) u_cs (
        .a_i      (sum0),
        .b_i      (sum1),
        .pick_b_o (dec_o)
    );

    assign pm_o = dec_o ? sum1 : sum0;

endmodule

// File: rtl/pmu_min_tree.sv
module pmu_min_tree #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N*W-1:0] vals_i,
    output logic [W-1:0]   min_o
);

    logic [W-1:0] node [1:2*N-1];

    for (genvar g = 0; g < N; g++) begin : g_leaf
        assign node[N+g] = vals_i[g*W +: W];
    end

    for (genvar k = 1; k < N; k++) begin : g_cell
        logic pick;
        pmu_cs2 #(.W(W)) u_cs (
            .a_i      (node[2*k]),
            .b_i      (node[2*k+1]),
            .pick_b_o (pick)
        );
        assign node[k] = pick ? node[2*k+1] : node[2*k];
    end

    assign min_o = node[1];

endmodule

// File: rtl/acs_pmu.sv
module acs_pmu #(
    parameter int M    = 3,
    parameter int W    = 8,
    parameter int BW   = 4,
    parameter int G0   = 15,
    parameter int G1   = 13,
    parameter int INIT = (1 << W) - 1 - (1 << (BW - 1))
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_in,
    input  logic                  start,
    input  logic [4*BW-1:0]       bm_in,
    output logic                  valid_out,
    output logic [(1<<M)*W-1:0]   pm_out,
    output logic [(1<<M)-1:0]     dec_out
);

    import pmu_pkg::*;

    localparam int N    = 1 << M;
    localparam int HALF = N / 2;

    pmu_state_e   state_q, state_d;
    logic         accept;
    logic [W-1:0] pm_q   [N];
    logic [W-1:0] pm_src [N];
    logic [W-1:0] pm_new [N];
    logic [W-1:0] pm_nrm [N];
    logic [N-1:0] dec_new;
    logic [N*W-1:0] pm_new_flat;
    logic [W-1:0] pm_min;

    // ---------------- controller ----------------
    assign accept = valid_in && (start || (state_q == ST_RUN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (valid_in && start) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // ---------------- predecessor metric source ----------------
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (start) pm_src[i] = (i == 0) ? '0 : W'(INIT);
            else       pm_src[i] = pm_q[i];
        end
    end

    // ---------------- ACS array ----------------
    for (genvar j = 0; j < N; j++) begin : g_acs
        localparam int P0   = j >> 1;
        localparam int P1   = P0 + HALF;
        localparam int V0   = j;
        localparam int V1   = j + N;
        localparam int SYM0 = 2 * int'(^(G0 & V0)) + int'(^(G1 & V0));
        localparam int SYM1 = 2 * int'(^(G0 & V1)) + int'(^(G1 & V1));

        pmu_acs #(.W(W), .BW(BW)) u_acs (
            .pm0_i (pm_src[P0]),
            .pm1_i (pm_src[P1]),
            .bm0_i (bm_in[SYM0*BW +: BW]),
            .bm1_i (bm_in[SYM1*BW +: BW]),
            .pm_o  (pm_new[j]),
            .dec_o (dec_new[j])
        );

        assign pm_new_flat[j*W +: W] = pm_new[j];
        assign pm_nrm[j]             = pm_new[j] - pm_min;
        assign pm_out[j*W +: W]      = pm_q[j];
    end

    // ---------------- normalization ----------------
    pmu_min_tree #(.N(N), .W(W)) u_min (
        .vals_i (pm_new_flat),
        .min_o  (pm_min)
    );

    // ---------------- output registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            dec_out   <= '0;
            for (int i = 0; i < N; i++) pm_q[i] <= '0;
        end else begin
            valid_out <= accept;
            if (accept) begin
                dec_out <= dec_new;
                for (int i = 0; i < N; i++) pm_q[i] <= pm_nrm[i];
            end
        end
    end

endmodule

// File: rtl/acs_pmu_chk.sv
module acs_pmu_chk #(
    parameter int N = 8,
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           valid_in,
    input logic           start,
    input logic           run_i,
    input logic           valid_out,
    input logic [N*W-1:0] pm_out,
    input logic [N-1:0]   dec_out
);

    logic any_zero;

    always_comb begin
        any_zero = 1'b0;
        for (int i = 0; i < N; i++)
            if (pm_out[i*W +: W] == '0) any_zero = 1'b1;
    end

    p_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && (run_i || start)) |=> valid_out);

    p_novalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(pm_out) && $stable(dec_out)));

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !start && !run_i) |=> !valid_out);

    p_zero_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> any_zero);

    p_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && start) |=> (dec_out[1:0] == 2'b00));

endmodule

bind acs_pmu acs_pmu_chk #(.N(N), .W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .start     (start),
    .run_i     (state_q == pmu_pkg::ST_RUN),
    .valid_out (valid_out),
    .pm_out    (pm_out),
    .dec_out   (dec_out)
);

// File: tb/acs_pmu_test.sv
`timescale 1ns/1ps
module acs_pmu_test;

    localparam int M    = 3;
    localparam int N    = 8;
    localparam int W    = 8;
    localparam int BW   = 4;
    localparam int G0   = 15;
    localparam int G1   = 13;
    localparam int INIT = 247;
    localparam int MAXV = 255;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 valid_in;
    logic                 start;
    logic [4*BW-1:0]      bm_in;
    logic                 valid_out;
    logic [N*W-1:0]       pm_out;
    logic [N-1:0]         dec_out;

    int checks = 0;
    int bad    = 0;
    bit done   = 0;
    int ref_pm [N];
    logic [N-1:0] ref_dec;
    bit ref_run = 0;

    always #2.5 clk = ~clk;

    acs_pmu #(.M(M), .W(W), .BW(BW), .G0(G0), .G1(G1), .INIT(INIT)) uut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .start(start),
        .bm_in(bm_in), .valid_out(valid_out), .pm_out(pm_out), .dec_out(dec_out)
    );

    // {valid, start, bm3 bm2 bm1 bm0}
    localparam logic [17:0] STIM [16] = '{
        {2'b11, 16'hF920}, {2'b10, 16'h1234}, {2'b10, 16'h0000}, {2'b00, 16'hFFFF},
        {2'b10, 16'hF0F0}, {2'b10, 16'h5A5A}, {2'b10, 16'h7777}, {2'b11, 16'hFFFF},
        {2'b10, 16'h0F0F}, {2'b10, 16'h3C21}, {2'b00, 16'h0000}, {2'b10, 16'hE1D2},
        {2'b10, 16'h8888}, {2'b10, 16'h0123}, {2'b10, 16'hFEDC}, {2'b10, 16'h4444}
    };

    function automatic int par(input int x);
        int c = 0;
        for (int i = 0; i < 32; i++) c += (x >> i) & 1;
        return c % 2;
    endfunction

    task automatic model(input bit st, input logic [15:0] bm);
        int nw [N];
        int mn = MAXV + 1;
        for (int j = 0; j < N; j++) begin
            int p0 = j >> 1;
            int p1 = p0 + N / 2;
            int m0 = st ? ((p0 == 0) ? 0 : INIT) : ref_pm[p0];
            int m1 = st ? INIT : ref_pm[p1];
            int y0 = 2 * par(G0 & j) + par(G1 & j);
            int y1 = 2 * par(G0 & (j + N)) + par(G1 & (j + N));
            int s0 = m0 + int'(bm[y0*4 +: 4]);
            int s1 = m1 + int'(bm[y1*4 +: 4]);
            if (s0 > MAXV) s0 = MAXV;
            if (s1 > MAXV) s1 = MAXV;
            if (s0 <= s1) begin nw[j] = s0; ref_dec[j] = 1'b0; end
            else          begin nw[j] = s1; ref_dec[j] = 1'b1; end
            if (nw[j] < mn) mn = nw[j];
        end
        for (int j = 0; j < N; j++) ref_pm[j] = nw[j] - mn;
    endtask

    function automatic logic [63:0] pack_ref();
        logic [63:0] v = '0;
        for (int j = 0; j < N; j++) v[j*W +: W] = W'(ref_pm[j]);
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] prev_pm;
        logic [7:0]  prev_dec;
        bit          acc;
        logic [17:0] row;
        bit          anyz;

        rst_n = 1'b0; valid_in = 1'b0; start = 1'b0; bm_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        chk(valid_out == 1'b0, "R9 valid_out", 64'(valid_out), 64'd0);
        chk(pm_out == '0, "R9 pm_out", pm_out, 64'd0);
        chk(dec_out == '0, "R9 dec_out", 64'(dec_out), 64'd0);

        // R6: valid without start in idle is ignored
        valid_in = 1'b1; start = 1'b0; bm_in = 16'h1357;
        @(negedge clk);
        chk(valid_out == 1'b0, "R6 valid_out", 64'(valid_out), 64'd0);
        chk(pm_out == '0, "R6 pm_out", pm_out, 64'd0);
        valid_in = 1'b0;
        @(negedge clk);

        for (int r = 0; r < 16; r++) begin
            row      = STIM[r];
            acc      = row[17] && (ref_run || row[16]);
            prev_pm  = pm_out;
            prev_dec = dec_out;
            valid_in = row[17];
            start    = row[16];
            bm_in    = row[15:0];
            if (acc) begin
                model(row[16], row[15:0]);
                ref_run = 1;
            end
            @(negedge clk);
            if (acc) begin
                chk(valid_out == 1'b1, "R7 valid_out", 64'(valid_out), 64'd1);
                chk(pm_out == pack_ref(), "R1 R2 R3 metrics", pm_out, pack_ref());
                chk(dec_out == ref_dec, "R4 decisions", 64'(dec_out), 64'(ref_dec));
                anyz = 0;
                for (int j = 0; j < N; j++) if (pm_out[j*W +: W] == 0) anyz = 1;
                chk(anyz, "R3 zero metric", 64'(anyz), 64'd1);
                if (row[16])
                    chk(dec_out[1:0] == 2'b00, "R5 seed decisions", 64'(dec_out[1:0]), 64'd0);
                if (r == 7) begin
                    // hand value: 247+15 clamps to 255, minus minimum 15
                    chk(pm_out[2*W +: W] == 8'd240, "R2 clamp", 64'(pm_out[2*W +: W]), 64'd240);
                    chk(pm_out[0 +: W] == 8'd0, "R5 state0", 64'(pm_out[0 +: W]), 64'd0);
                end
            end else begin
                chk(valid_out == 1'b0, "R8 valid_out", 64'(valid_out), 64'd0);
                chk(pm_out == prev_pm, "R8 pm hold", pm_out, prev_pm);
                chk(dec_out == prev_dec, "R8 dec hold", 64'(dec_out), 64'(prev_dec));
            end
        end

        // R7: pulse ends once inputs go quiet
        valid_in = 1'b0; start = 1'b0;
        @(negedge clk);
        chk(valid_out == 1'b0, "R7 pulse end", 64'(valid_out), 64'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule